// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the word address for every cycle of a short burst on a synchronous memory port. The host presents a start address once. On each following cycle the block supplies the next address of the group of four, so the host does not have to drive the address bus again. A low level on the load control captures a new start address. A high level on the same control steps an internal beat counter. A static order input chooses how the two low address bits move through the burst. In linear order they count upward and wrap. In interleaved order they are the start bits XOR the beat number. The upper address bits never change within a burst.

An active-low clock enable freezes the whole block, including its outputs. A set of chip-select inputs qualifies each load. If any select is inactive when a load is issued, no burst starts and any burst in progress is dropped. A valid flag is high only while a selected burst is running. Both outputs are registered, so every decision taken at a clock edge shows at the outputs right after that edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high, the next edge drives addr_vld to 0 and addr_out to all zeros.
- R2: An edge with clk_en_n=0, load_n=0 and every bit of sel_in at 1 starts a burst: right after that edge addr_vld is 1 and addr_out equals addr_in as sampled.
- R3: With order_sel=0 (linear), each edge with clk_en_n=0 and load_n=1 during a burst sets the low two bits of addr_out to (start + beats) mod 4. Bits above bit 1 keep the start value.
- R4: With order_sel=1 (interleaved), each such step sets the low two bits of addr_out to start XOR (beats mod 4). The upper bits stay fixed.
- R5: The fifth address of a burst (after four steps) equals the start address, and stepping goes on wrapping inside the same group of four. It never carries into bit 2.
- R6: An edge with clk_en_n=1 changes neither addr_out nor addr_vld, whatever load_n, sel_in and addr_in are. The burst resumes from the same beat once clk_en_n returns to 0.
- R7: An edge with clk_en_n=0, load_n=0 and any bit of sel_in at 0 ends the burst: addr_vld becomes 0 and addr_out keeps its previous value.
- R8: An edge with clk_en_n=0 and load_n=1 while no burst is active is ignored: addr_vld stays 0 and addr_out is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes all state |
| load_n | input | 1 | Low loads a new start address, high steps the burst |
| sel_in | input | SEL_N | Chip-select qualifiers, all must be 1 for a load to start a burst |
| order_sel | input | 1 | 0 gives linear beat order, 1 gives interleaved (XOR) beat order |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current access address |
| addr_vld | output | 1 | High while a selected burst is active |

## Verification
Every result is due one clock after the edge that samples its stimulus. The state and the output registers update at the same edge, so a load shows its start address right after the capturing edge, and each step shows its new beat right after the stepping edge. The bench drives inputs on the falling edge and compares the outputs on the next falling edge, half a period after the rising edge that consumed them. Hold, terminate and idle-step cases are followed by several further falling-edge checks, so a late or early change would also be caught.

// File: rtl/bag_pkg.sv
package bag_pkg;

  // Beat ordering selected by the static order input
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  // Per-cycle action decided from the controls
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,  // clock enable inactive: freeze
    OP_LOAD = 3'd1,  // selected load: new burst
    OP_DROP = 3'd2,  // deselected load: end burst
    OP_STEP = 3'd3,  // advance within active burst
    OP_IDLE = 3'd4   // advance with no burst: ignored
  } op_e;

endpackage

// File: rtl/bag_op_decode.sv
module bag_op_decode
  import bag_pkg::*;
#(
  parameter int SEL_N = 3
) (
  input  logic             clk_en_n,
  input  logic             load_n,
  input  logic [SEL_N-1:0] sel_in,
  input  logic             active,
  output op_e              op
);

  // AND chain across all select qualifiers
  logic [SEL_N:0] sel_chain;
  assign sel_chain[0] = 1'b1;

  for (genvar i = 0; i < SEL_N; i++) begin : g_sel
    assign sel_chain[i+1] = sel_chain[i] & sel_in[i];
  end

  logic all_sel;
  assign all_sel = sel_chain[SEL_N];

  always_comb begin
    if (clk_en_n) begin
      op = OP_HOLD;
    end else if (!load_n) begin
      op = all_sel ? OP_LOAD : OP_DROP;
    end else begin
      op = active ? OP_STEP : OP_IDLE;
    end
  end

endmodule

// File: rtl/bag_burst_state.sv
module bag_burst_state
  import bag_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int BEAT_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  op_e                  op,
  input  logic [ADDR_W-1:0]    addr_in,
  output logic                 act_q,
  output logic [ADDR_W-1:0]    nxt_base,
  output logic [BEAT_BITS-1:0] nxt_cnt,
  output logic                 nxt_act
);

  logic [ADDR_W-1:0]    base_q;
  logic [BEAT_BITS-1:0] cnt_q;

  always_comb begin
    nxt_base = base_q;
    nxt_cnt  = cnt_q;
    nxt_act  = act_q;
    unique case (op)
      OP_LOAD: begin
        nxt_base = addr_in;
        nxt_cnt  = '0;
        nxt_act  = 1'b1;
      end
      OP_DROP: begin
        nxt_act  = 1'b0;
      end
      OP_STEP: begin
        // natural wrap of the beat counter keeps the burst in its group
        nxt_cnt  = cnt_q + 1'b1;
      end
      default: begin
        // OP_HOLD and OP_IDLE keep everything
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      base_q <= nxt_base;
      cnt_q  <= nxt_cnt;
      act_q  <= nxt_act;
    end
  end

endmodule

// File: rtl/bag_beat_map.sv
module bag_beat_map
  import bag_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int BEAT_BITS = 2
) (
  input  logic [ADDR_W-1:0]    base,
  input  logic [BEAT_BITS-1:0] cnt,
  input  order_e               order,
  output logic [ADDR_W-1:0]    addr
);

  localparam int UPPER_W = ADDR_W - BEAT_BITS;

  logic [BEAT_BITS-1:0] low_lin;
  logic [BEAT_BITS-1:0] low_xor;

  assign low_lin = base[BEAT_BITS-1:0] + cnt;

  for (genvar b = 0; b < BEAT_BITS; b++) begin : g_xor
    assign low_xor[b] = base[b] ^ cnt[b];
  end

  if (UPPER_W > 0) begin : g_upper
    assign addr[ADDR_W-1:BEAT_BITS] = base[ADDR_W-1:BEAT_BITS];
  end

  assign addr[BEAT_BITS-1:0] = (order == ORD_XOR) ? low_xor : low_lin;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int SEL_N     = 3,
  parameter int BEAT_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_n,
  input  logic              load_n,
  input  logic [SEL_N-1:0]  sel_in,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_vld
);

  op_e                  op;
  logic                 act_q;
  logic [ADDR_W-1:0]    nxt_base;
  logic [BEAT_BITS-1:0] nxt_cnt;
  logic                 nxt_act;
  logic [ADDR_W-1:0]    mapped;
  order_e               order;

  assign order = order_e'(order_sel);

  bag_op_decode #(
    .SEL_N (SEL_N)
  ) u_dec (
    .clk_en_n (clk_en_n),
    .load_n   (load_n),
    .sel_in   (sel_in),
    .active   (act_q),
    .op       (op)
  );

  bag_burst_state #(
    .ADDR_W    (ADDR_W),
    .BEAT_BITS (BEAT_BITS)
  ) u_state (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .addr_in  (addr_in),
    .act_q    (act_q),
    .nxt_base (nxt_base),
    .nxt_cnt  (nxt_cnt),
    .nxt_act  (nxt_act)
  );

  bag_beat_map #(
    .ADDR_W    (ADDR_W),
    .BEAT_BITS (BEAT_BITS)
  ) u_map (
    .base  (nxt_base),
    .cnt   (nxt_cnt),
    .order (order),
    .addr  (mapped)
  );

  // Registered outputs, updated in step with the burst state
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      addr_vld <= 1'b0;
    end else if (op != OP_HOLD) begin
      addr_vld <= nxt_act;
      if (nxt_act) begin
        addr_out <= mapped;
      end
    end
  end

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W    = 17,
  parameter int SEL_N     = 3,
  parameter int BEAT_BITS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en_n,
  input logic              load_n,
  input logic [SEL_N-1:0]  sel_in,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_vld
);

  AST_RST_IDLE: assert property (@(posedge clk)
    rst |=> (!addr_vld && addr_out == '0)); // R1

  AST_LOAD_START: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !load_n && (&sel_in)) |=> (addr_vld && addr_out == $past(addr_in))); // R2

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && load_n && addr_vld)
      |=> (addr_vld && addr_out[ADDR_W-1:BEAT_BITS] == $past(addr_out[ADDR_W-1:BEAT_BITS]))); // R3

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && load_n && addr_vld && !order_sel && !$past(order_sel))
      |=> (addr_out[BEAT_BITS-1:0] == BEAT_BITS'($past(addr_out[BEAT_BITS-1:0]) + 1'b1))); // R3

  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(addr_out) && $stable(addr_vld))); // R6

  AST_DESEL_END: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !load_n && !(&sel_in)) |=> (!addr_vld && $stable(addr_out))); // R7

  AST_IDLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && load_n && !addr_vld) |=> (!addr_vld && $stable(addr_out))); // R8

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
  .ADDR_W    (ADDR_W),
  .SEL_N     (SEL_N),
  .BEAT_BITS (BEAT_BITS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_en_n  (clk_en_n),
  .load_n    (load_n),
  .sel_in    (sel_in),
  .order_sel (order_sel),
  .addr_in   (addr_in),
  .addr_out  (addr_out),
  .addr_vld  (addr_vld)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  localparam int AW = 17;
  localparam int SN = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          clk_en_n;
  logic          load_n;
  logic [SN-1:0] sel_in;
  logic          order_sel;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic          addr_vld;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .SEL_N(SN), .BEAT_BITS(2)) u_dut (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .load_n(load_n),
    .sel_in(sel_in), .order_sel(order_sel), .addr_in(addr_in),
    .addr_out(addr_out), .addr_vld(addr_vld)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic [AW-1:0] ea, input logic ev, input string tag);
    n_chk++;
    if (addr_out !== ea || addr_vld !== ev) begin
      n_fail++;
      $display("FAIL %s: addr=%h vld=%b expected addr=%h vld=%b",
               tag, addr_out, addr_vld, ea, ev);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int k, input bit m);
    logic [1:0] s;
    logic [1:0] kk;
    s  = b[1:0];
    kk = 2'(k % 4);
    return {b[AW-1:2], (m ? (s ^ kk) : 2'((int'(s) + k) % 4))};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [AW-1:0] b;
    logic [AW-1:0] held;
    rst = 1'b1; clk_en_n = 1'b0; load_n = 1'b1; sel_in = '1;
    order_sel = 1'b0; addr_in = '0;
    @(negedge clk);
    tick();
    check('0, 1'b0, "R1 reset state");
    rst = 1'b0;

    // Sweep: both orders, all start beats, several upper patterns
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int u = 0; u < 3; u++) begin
          b = {(u == 0) ? 15'h0000 : (u == 1) ? 15'h2A5B : 15'h7FFF, 2'(s)};
          order_sel = m[0];
          load_n = 1'b0; sel_in = '1; addr_in = b;
          tick();
          check(b, 1'b1, "R2 load start");
          load_n = 1'b1; addr_in = ~b;
          for (int k = 1; k <= 6; k++) begin
            tick();
            if (k == 4)
              check(exp_addr(b, k, m[0]), 1'b1, "R5 wrap to start");
            else if (m == 0)
              check(exp_addr(b, k, 1'b0), 1'b1, "R3 linear step");
            else
              check(exp_addr(b, k, 1'b1), 1'b1, "R4 interleaved step");
          end
        end
      end
    end

    // Clock enable freeze mid-burst
    b = 17'h1_2346; order_sel = 1'b0;
    load_n = 1'b0; sel_in = '1; addr_in = b;
    tick();
    load_n = 1'b1;
    tick();
    check(exp_addr(b, 1, 1'b0), 1'b1, "R3 step before freeze");
    clk_en_n = 1'b1; load_n = 1'b0; addr_in = 17'h0_0F0F; sel_in = '0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(exp_addr(b, 1, 1'b0), 1'b1, "R6 frozen");
    end
    clk_en_n = 1'b0; load_n = 1'b1; sel_in = '1;
    tick();
    check(exp_addr(b, 2, 1'b0), 1'b1, "R6 resume beat");

    // Deselected load ends the burst, for each select bit
    for (int j = 0; j < SN; j++) begin
      b = 17'h0_4441 + 17'(j * 4);
      order_sel = 1'b1;
      load_n = 1'b0; sel_in = '1; addr_in = b;
      tick();
      load_n = 1'b1;
      tick();
      held = exp_addr(b, 1, 1'b1);
      check(held, 1'b1, "R4 step before drop");
      load_n = 1'b0; sel_in = '1; sel_in[j] = 1'b0; addr_in = 17'h1_FFFC;
      tick();
      check(held, 1'b0, "R7 deselect ends burst");
      // Steps while idle are ignored
      load_n = 1'b1; sel_in = '1; addr_in = 17'h0_0003;
      for (int i = 0; i < 3; i++) begin
        tick();
        check(held, 1'b0, "R8 idle step ignored");
      end
    end

    // Reset in the middle of a burst
    load_n = 1'b0; sel_in = '1; addr_in = 17'h0_7777;
    tick();
    rst = 1'b1; load_n = 1'b1;
    tick();
    check('0, 1'b0, "R1 reset mid burst");
    rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule